// File: doc/BRIEF.md
# Barrel Shift/Rotate Unit

This block shifts or rotates a 32-bit operand by a count taken from a register. It handles seven operations: logical left and right shifts, arithmetic right shift, left and right rotates, and left and right double-register (funnel) shifts. A funnel shift fills the vacated positions with bits from a second operand. An eighth code passes the operand through unchanged. The datapath is a logarithmic network of constant-shift stages. Stage k shifts by 2^k and is enabled by count bit k, so every count from 0 to 31 takes the same path depth.

Left-hand operations reuse the same right-shifting network. The operand bits are mirrored on the way in and mirrored back on the way out. A policy input picks how counts of 32 or more are treated. In wrap mode the count is reduced to its low five bits. In clamp mode a logical shift clears the result, and an arithmetic shift fills the result with the sign bit. Rotates and funnel shifts always wrap. The carry output is the last bit pushed out of the operand. Results and carry are registered, so they appear one clock after the inputs are sampled.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_o` becomes zero and `carry_o` becomes 0 after that edge.
- R2: Op code 0 shifts `a_i` left and op code 1 shifts it right, filling the vacated bits with zeros.
- R3: Op code 2 shifts `a_i` right and copies bit 31 into the vacated bits.
- R4: Op code 3 rotates `a_i` left and op code 4 rotates it right, both by the count modulo 32, whatever the value of `sat_mode_i`.
- R5: Op code 5 gives `(a_i << n) | (b_i >> (32-n))` and op code 6 gives `(a_i >> n) | (b_i << (32-n))`, where n is the count modulo 32, whatever the value of `sat_mode_i`.
- R6: With `sat_mode_i` = 0, only `cnt_i[4:0]` affects any operation, so a count of 35 gives the same result and carry as a count of 3.
- R7: With `sat_mode_i` = 1 and `cnt_i` >= 32, op codes 0 and 1 give a zero result and a zero carry.
- R8: With `sat_mode_i` = 1 and `cnt_i` >= 32, op code 2 gives 32 copies of `a_i[31]` and a carry equal to `a_i[31]`.
- R9: `carry_o` is the last bit moved out of `a_i`: `a_i[32-n]` for the left-hand ops (0, 3, 5) and `a_i[n-1]` for the right-hand ops (1, 2, 4, 6). When the effective count n is 0, `res_o` equals `a_i` and `carry_o` equals `carry_i`.
- R10: Op code 7 returns `a_i` and `carry_i` unchanged, whatever the count.
- R11: Inputs sampled at one rising edge appear on `res_o` and `carry_o` after that same edge, which is a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code (0 to 7, as listed in the requirements) |
| sat_mode_i | input | 1 | Count policy: 0 wraps the count, 1 clamps large counts for shifts |
| a_i | input | 32 | Operand that is shifted or rotated |
| b_i | input | 32 | Fill source for the funnel shifts |
| cnt_i | input | 8 | Shift or rotate count |
| carry_i | input | 1 | Carry returned when the effective count is zero |
| res_o | output | 32 | Registered result |
| carry_o | output | 1 | Registered carry-out |

## Verification
The assertions check several properties on every cycle. They check the clamped outcomes for logical and arithmetic shifts, and that rotates keep the same number of set bits. They check that a zero effective count and the pass-through code both return the operand and the incoming carry, and that reset clears the outputs. The exact bit patterns of each shift, rotate and funnel shift, the carry taken from the right bit position, and the wrap of counts such as 35 and 255 to their low five bits can only be shown by the bench. It does this by comparing every registered output against its own arithmetic model.

// File: rtl/sru_pkg.sv
package sru_pkg;
  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_SAR  = 3'd2,
    OP_ROL  = 3'd3,
    OP_ROR  = 3'd4,
    OP_FSHL = 3'd5,
    OP_FSHR = 3'd6,
    OP_PASS = 3'd7
  } sru_op_e;

  function automatic logic is_left(input sru_op_e op);
    return (op == OP_SHL) || (op == OP_ROL) || (op == OP_FSHL);
  endfunction
endpackage

// File: rtl/sru_fill_select.sv
// Builds the extended right-shift input {fill, operand, carry_in}.
// Left-hand operations are mirrored so one right-shift network serves all.
module sru_fill_select
  import sru_pkg::*;
#(
  parameter int W = 32,
  localparam int EW = 2 * W + 1
) (
  input  sru_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic           left,
  output logic [EW-1:0]  ext
);
  logic [W-1:0] a_rev, b_rev, lo, hi;

  generate
    for (genvar i = 0; i < W; i++) begin : g_rev
      assign a_rev[i] = a[W-1-i];
      assign b_rev[i] = b[W-1-i];
    end
  endgenerate

  assign left = is_left(op);
  assign lo   = left ? a_rev : a;

  always_comb begin
    unique case (op)
      OP_SAR:  hi = {W{a[W-1]}};
      OP_ROL:  hi = a_rev;
      OP_ROR:  hi = a;
      OP_FSHL: hi = b_rev;
      OP_FSHR: hi = b;
      default: hi = '0;
    endcase
  end

  assign ext = {hi, lo, cin};
endmodule

// File: rtl/sru_stage_net.sv
// Cascade of constant right shifts; stage k moves the vector by 2**k
// when count bit k is set.
module sru_stage_net #(
  parameter int W  = 32,
  parameter int CW = 5,
  localparam int EW = 2 * W + 1
) (
  input  logic [EW-1:0] ext,
  input  logic [CW-1:0] cnt,
  output logic [W:0]    low
);
  logic [EW-1:0] stage [CW+1];
  logic          unused_hi_bits;

  assign stage[0] = ext;

  generate
    for (genvar k = 0; k < CW; k++) begin : g_stage
      localparam int SH = 1 << k;
      assign stage[k+1] = cnt[k] ? {{SH{1'b0}}, stage[k][EW-1:SH]} : stage[k];
    end
  endgenerate

  assign low            = stage[CW][W:0];
  assign unused_hi_bits = ^stage[CW][EW-1:W+1];
endmodule

// File: rtl/sru_result_fix.sv
// Un-mirrors left-hand results and applies the clamp overrides.
module sru_result_fix #(
  parameter int W = 32
) (
  input  logic [W:0]   low,
  input  logic         left,
  input  logic         clamp_zero,
  input  logic         clamp_sign,
  input  logic         sign,
  output logic [W-1:0] res,
  output logic         carry
);
  logic [W-1:0] body, body_rev;

  assign body = low[W:1];

  generate
    for (genvar i = 0; i < W; i++) begin : g_unrev
      assign body_rev[i] = body[W-1-i];
    end
  endgenerate

  always_comb begin
    if (clamp_zero) begin
      res   = '0;
      carry = 1'b0;
    end else if (clamp_sign) begin
      res   = {W{sign}};
      carry = sign;
    end else begin
      res   = left ? body_rev : body;
      carry = low[0];
    end
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int W        = 32,
  parameter int CNT_IN_W = 8,
  localparam int CW = $clog2(W),
  localparam int EW = 2 * W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          op_i,
  input  logic                sat_mode_i,
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  input  logic [CNT_IN_W-1:0] cnt_i,
  input  logic                carry_i,
  output logic [W-1:0]        res_o,
  output logic                carry_o
);
  sru_op_e       op;
  logic          left, big, clamp_zero, clamp_sign;
  logic [CW-1:0] eff_cnt;
  logic [EW-1:0] ext;
  logic [W:0]    low;
  logic [W-1:0]  res_d;
  logic          carry_d;

  assign op = sru_op_e'(op_i);

  generate
    if (CNT_IN_W > CW) begin : g_big
      assign big = |cnt_i[CNT_IN_W-1:CW];
    end else begin : g_nobig
      assign big = 1'b0;
    end
  endgenerate

  assign eff_cnt    = (op == OP_PASS) ? '0 : cnt_i[CW-1:0];
  assign clamp_zero = sat_mode_i && big && ((op == OP_SHL) || (op == OP_SHR));
  assign clamp_sign = sat_mode_i && big && (op == OP_SAR);

  sru_fill_select #(.W(W)) u_fill (
    .op   (op),
    .a    (a_i),
    .b    (b_i),
    .cin  (carry_i),
    .left (left),
    .ext  (ext)
  );

  sru_stage_net #(.W(W), .CW(CW)) u_net (
    .ext (ext),
    .cnt (eff_cnt),
    .low (low)
  );

  sru_result_fix #(.W(W)) u_fix (
    .low        (low),
    .left       (left),
    .clamp_zero (clamp_zero),
    .clamp_sign (clamp_sign),
    .sign       (a_i[W-1]),
    .res        (res_d),
    .carry      (carry_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      res_o   <= res_d;
      carry_o <= carry_d;
    end
  end
endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
  parameter int W        = 32,
  parameter int CNT_IN_W = 8,
  localparam int CW = $clog2(W)
) (
  input logic                clk,
  input logic                rst,
  input logic [2:0]          op_i,
  input logic                sat_mode_i,
  input logic [W-1:0]        a_i,
  input logic [W-1:0]        b_i,
  input logic [CNT_IN_W-1:0] cnt_i,
  input logic                carry_i,
  input logic [W-1:0]        res_o,
  input logic                carry_o
);
  logic pv;
  logic unused_chk_b;

  assign unused_chk_b = ^b_i;

  always_ff @(posedge clk) begin
    if (rst) pv <= 1'b0;
    else     pv <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !carry_o));

  // R7
  clamp_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(sat_mode_i) && ($past(cnt_i) >= W) &&
     ($past(op_i) == 3'd0 || $past(op_i) == 3'd1))
    |-> (res_o == '0 && !carry_o));

  // R8
  clamp_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(sat_mode_i) && ($past(cnt_i) >= W) && $past(op_i) == 3'd2)
    |-> (res_o == {W{$past(a_i[W-1])}} && carry_o == $past(a_i[W-1])));

  // R4
  rotate_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (pv && ($past(op_i) == 3'd3 || $past(op_i) == 3'd4))
    |-> ($countones(res_o) == $countones($past(a_i))));

  // R10
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(op_i) == 3'd7)
    |-> (res_o == $past(a_i) && carry_o == $past(carry_i)));

  // R9
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(cnt_i[CW-1:0]) == '0 &&
     !($past(sat_mode_i) && $past(cnt_i) >= W))
    |-> (res_o == $past(a_i) && carry_o == $past(carry_i)));
endmodule

bind shift_rotate_unit sru_checker #(.W(W), .CNT_IN_W(CNT_IN_W)) u_chk (.*);

// File: tb/tb_shift_rotate_unit.sv
`timescale 1ns/1ps
module tb_shift_rotate_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op_i;
  logic        sat_mode_i;
  logic [31:0] a_i, b_i;
  logic [7:0]  cnt_i;
  logic        carry_i;
  logic [31:0] res_o;
  logic        carry_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] exp_r;
  logic        exp_c;
  string       exp_tag;
  bit          have_exp = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  shift_rotate_unit dut (
    .clk(clk), .rst(rst), .op_i(op_i), .sat_mode_i(sat_mode_i),
    .a_i(a_i), .b_i(b_i), .cnt_i(cnt_i), .carry_i(carry_i),
    .res_o(res_o), .carry_o(carry_o)
  );

  function automatic logic [31:0] nextrand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Behavioural model written from the requirements.
  function automatic void model(input logic [2:0] op, input logic sat,
                                input logic [31:0] a, input logic [31:0] b,
                                input logic [7:0] cnt, input logic cin,
                                output logic [31:0] r, output logic c);
    int n;
    bit big;
    n   = int'(cnt[4:0]);
    big = (cnt >= 8'd32);
    r   = a;
    c   = cin;
    case (op)
      3'd0: if (sat && big) begin r = 0; c = 0; end
            else if (n != 0) begin r = a << n; c = a[32-n]; end
      3'd1: if (sat && big) begin r = 0; c = 0; end
            else if (n != 0) begin r = a >> n; c = a[n-1]; end
      3'd2: if (sat && big) begin r = {32{a[31]}}; c = a[31]; end
            else if (n != 0) begin r = 32'($signed(a) >>> n); c = a[n-1]; end
      3'd3: if (n != 0) begin r = (a << n) | (a >> (32-n)); c = a[32-n]; end
      3'd4: if (n != 0) begin r = (a >> n) | (a << (32-n)); c = a[n-1]; end
      3'd5: if (n != 0) begin r = (a << n) | (b >> (32-n)); c = a[32-n]; end
      3'd6: if (n != 0) begin r = (a >> n) | (b << (32-n)); c = a[n-1]; end
      default: ;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic sat,
                                   input logic [7:0] cnt);
    if (sat && cnt >= 8'd32 && (op == 3'd0 || op == 3'd1)) return "R7";
    if (sat && cnt >= 8'd32 && op == 3'd2) return "R8";
    if (!sat && cnt >= 8'd32) return "R6";
    if (cnt[4:0] == 5'd0) return "R9";
    case (op)
      3'd0, 3'd1: return "R2";
      3'd2:       return "R3";
      3'd3, 3'd4: return "R4";
      3'd5, 3'd6: return "R5";
      default:    return "R10";
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (res_o !== exp_r || carry_o !== exp_c) begin
      errors++;
      $display("FAIL %s/R11: res=%h carry=%b expected res=%h carry=%b",
               exp_tag, res_o, carry_o, exp_r, exp_c);
    end
  endtask

  // Compare the result of the previous cycle, then drive the next operation.
  task automatic step(input logic [2:0] op, input logic sat, input logic [31:0] a,
                      input logic [31:0] b, input logic [7:0] cnt, input logic cin,
                      input string tag);
    @(negedge clk);
    if (have_exp) compare();
    op_i = op; sat_mode_i = sat; a_i = a; b_i = b; cnt_i = cnt; carry_i = cin;
    model(op, sat, a, b, cnt, cin, exp_r, exp_c);
    exp_tag  = tag;
    have_exp = 1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (have_exp) compare();
    have_exp = 0;
  endtask

  task automatic reset_check();
    @(negedge clk);
    rst = 1'b1;
    op_i = 3'd7; a_i = 32'hFFFF_FFFF; carry_i = 1'b1;
    @(negedge clk);
    checks++;
    if (res_o !== 32'h0 || carry_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: res=%h carry=%b expected res=00000000 carry=0", res_o, carry_o);
    end
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_i = 0; sat_mode_i = 0; a_i = 0; b_i = 0; cnt_i = 0; carry_i = 0;
    repeat (2) @(posedge clk);
    reset_check();

    // R2 logical shifts
    step(3'd0, 0, 32'h8000_0001, 0, 8'd1, 0, "R2");
    step(3'd1, 0, 32'h8000_0001, 0, 8'd1, 0, "R2");
    step(3'd0, 0, 32'hDEAD_BEEF, 0, 8'd31, 0, "R2");
    // R3 arithmetic right, negative and positive
    step(3'd2, 0, 32'h8000_0000, 0, 8'd4, 0, "R3");
    step(3'd2, 0, 32'h7000_0000, 0, 8'd31, 0, "R3");
    // R4 rotates, clamp mode has no effect
    step(3'd3, 0, 32'h8000_0001, 0, 8'd1, 0, "R4");
    step(3'd4, 1, 32'h1234_5678, 0, 8'd36, 0, "R4");
    step(3'd3, 1, 32'hF000_000F, 0, 8'd32, 1, "R4");
    // R5 funnel shifts
    step(3'd5, 0, 32'h1111_2222, 32'hABCD_EF01, 8'd8, 0, "R5");
    step(3'd6, 1, 32'h1111_2222, 32'hABCD_EF01, 8'd40, 0, "R5");
    // R6 wrap: 35 equals 3
    step(3'd0, 0, 32'hC000_0007, 0, 8'd35, 0, "R6");
    step(3'd0, 0, 32'hC000_0007, 0, 8'd3, 0, "R6");
    step(3'd1, 0, 32'h8000_0004, 0, 8'd255, 0, "R6");
    // R7 clamp logical
    step(3'd0, 1, 32'hFFFF_FFFF, 0, 8'd32, 1, "R7");
    step(3'd1, 1, 32'hFFFF_FFFF, 0, 8'd200, 1, "R7");
    // R8 clamp arithmetic
    step(3'd2, 1, 32'h8000_1234, 0, 8'd33, 0, "R8");
    step(3'd2, 1, 32'h7FFF_1234, 0, 8'd64, 1, "R8");
    // R9 zero count returns carry_i; R9 carry position
    step(3'd1, 0, 32'h5A5A_5A5A, 0, 8'd0, 1, "R9");
    step(3'd0, 0, 32'h4000_0000, 0, 8'd2, 0, "R9");
    step(3'd4, 0, 32'h0000_0010, 0, 8'd5, 0, "R9");
    // R10 pass-through ignores the count
    step(3'd7, 1, 32'hCAFE_F00D, 0, 8'd77, 1, "R10");
    step(3'd7, 0, 32'h0BAD_CAFE, 0, 8'd3, 0, "R10");

    // Mixed patterns across all codes and both policies
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb, rc;
      seed = nextrand(seed); ra = seed;
      seed = nextrand(seed); rb = seed;
      seed = nextrand(seed); rc = seed;
      step(rc[2:0], rc[3], ra, rb, rc[15:8], rc[4],
           tag_of(rc[2:0], rc[3], rc[15:8]));
    end
    flush();

    // R1 reset in the middle of a run
    reset_check();
    step(3'd3, 0, 32'h0000_0001, 0, 8'd31, 0, "R4");
    flush();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule